// File: doc/BRIEF.md
# Three-Lane Serial PCM Audio Receiver

This block takes serial PCM audio arriving on three data lanes that share one bit clock and one word clock. It captures a left and a right sample from each lane and hands all six to a downstream filter path as 24-bit two's-complement words, with a single valid strobe per frame. The framing is I2S-like. The word clock is low for the left channel and high for the right channel. The most significant bit of a channel arrives on the bit-clock period after the word-clock change.

The serial clocks are brought into the system clock domain through a synchroniser, and edges are found there. Two control inputs set the incoming word length (16, 20, 24 or 32 bits) and select the bit-clock edge on which data is sampled. Every word length is brought to the 24-bit output format. Short words get zero low-order bits, and words longer than 24 bits lose their extra low-order bits.

A small framing state machine sequences the capture. After reset it sits in `ST_HUNT` until it sees the word clock fall, then moves to `ST_LEFT`. A word-clock change in `ST_LEFT` stores the left words and moves to `ST_RIGHT`. A word-clock change in `ST_RIGHT` publishes the frame and returns to `ST_LEFT`. A word-clock rise seen in `ST_HUNT` leaves it in `ST_HUNT`.

Top module: `tri_lane_pcm_rx`

## Requirements
- R1: After reset, `samples_valid` is 0 and both sample buses are all zeros.
- R2: With `bit_clk_inv` = 0, the word clock and the lanes are sampled on the rising edge of `bit_clk`.
- R3: With `bit_clk_inv` = 1, the word clock and the lanes are sampled on the falling edge of `bit_clk`.
- R4: `word_len` = 2'b00 selects 16-bit words. The received bits fill output bits 23..8, and bits 7..0 are 0.
- R5: `word_len` = 2'b01 selects 20-bit words. The received bits fill output bits 23..4, and bits 3..0 are 0.
- R6: `word_len` = 2'b10 selects 24-bit words, which fill output bits 23..0.
- R7: `word_len` = 2'b11 selects 32-bit words. The first 24 bits received become the output, and the last 8 are dropped.
- R8: `word_clk` low carries the left channel and high carries the right channel. The MSB of a channel is sampled one bit-clock period after the sample edge on which the word-clock change is seen.
- R9: Bits that arrive after the configured word length, within the same word-clock phase, have no effect on the output.
- R10: `samples_valid` is a one-cycle pulse, raised when both channels of a frame have been captured on all lanes. All six samples change only in that cycle.
- R11: Lane n appears at bits [24n+23:24n] of `left_samples` and `right_samples`, and each lane is captured independently.
- R12: After reset, no frame is output until a word-clock fall has been seen. Data received before that fall is discarded.
- R13: In 24-bit mode, a shorter source word followed by zero bits, in a phase of at least 24 bit clocks, appears MSB-aligned with zero low-order bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_clk | input | 1 | Serial bit clock (asynchronous) |
| word_clk | input | 1 | Left/right word clock (asynchronous) |
| lane_data | input | 3 | Serial data, one bit per lane |
| word_len | input | 2 | Input word length: 00=16, 01=20, 10=24, 11=32 |
| bit_clk_inv | input | 1 | 0: sample on rising bit_clk edge, 1: on falling edge |
| left_samples | output | 72 | Left samples, 24 bits per lane |
| right_samples | output | 72 | Right samples, 24 bits per lane |
| samples_valid | output | 1 | One-cycle pulse when a new frame is published |

## Verification
The zero-padding assertions assume that `word_len` stays constant across every frame published after the setting changes. The bench therefore changes the setting only before a frame whose data is all zeros. All checks assume that each half-period of the bit clock lasts at least two system clocks. The bench drives the bit clock with six system clocks per period. It moves data and the word clock one system clock after the driving edge, so sampling on the wrong edge would pick up stale bits. Polarity is changed only while `bit_clk` rests at its sampling level, so the change does not create a false sample edge.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

    typedef enum logic [1:0] {
        WL_16 = 2'b00,
        WL_20 = 2'b01,
        WL_24 = 2'b10,
        WL_32 = 2'b11
    } wlen_e;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } frame_st_e;

    // number of leading bits of a word that reach the output
    function automatic logic [5:0] kept_bits(input wlen_e wl);
        unique case (wl)
            WL_16:   return 6'd16;
            WL_20:   return 6'd20;
            default: return 6'd24;
        endcase
    endfunction

endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= din;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/pcm_rx_framer.sv
module pcm_rx_framer
    import pcm_rx_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_s,
    input  logic          ws_s,
    input  logic          inv,
    output logic          shift_en,
    output logic          end_left,
    output logic          end_right,
    output logic [CW-1:0] bit_idx
);
    localparam logic [CW-1:0] IDX_MAX = '1;

    frame_st_e state_q, state_d;
    logic      sclk_prev, ws_prev;
    logic      tick, trans;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            ws_prev   <= 1'b0;
        end else begin
            sclk_prev <= sclk_s;
            if (tick) ws_prev <= ws_s;
        end
    end

    assign tick  = inv ? (sclk_prev & ~sclk_s) : (sclk_s & ~sclk_prev);
    assign trans = tick && (ws_s != ws_prev);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:  if (trans && !ws_s) state_d = ST_LEFT;
            ST_LEFT:  if (trans)          state_d = ST_RIGHT;
            ST_RIGHT: if (trans)          state_d = ST_LEFT;
            default:                      state_d = ST_HUNT;
        endcase
    end

    // outputs
    always_comb begin
        shift_en  = tick && (state_q != ST_HUNT);
        end_left  = trans && (state_q == ST_LEFT);
        end_right = trans && (state_q == ST_RIGHT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          bit_idx <= '0;
        else if (trans)                      bit_idx <= '0;
        else if (tick && bit_idx != IDX_MAX) bit_idx <= bit_idx + 1'b1;
    end

    // R9: bit position saturates, so late bits can never wrap into the word
    assert_idx_saturates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_idx == IDX_MAX && !trans) |=> bit_idx == IDX_MAX);

    // R8: closing a right phase always returns to the left phase
    assert_right_then_left_R8: assert property (@(posedge clk) disable iff (!rst_n)
        end_right |=> state_q == ST_LEFT);
endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane #(
    parameter int SW = 24,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sd,
    input  logic          shift_en,
    input  logic          end_left,
    input  logic          end_right,
    input  logic [CW-1:0] bit_idx,
    input  logic [CW-1:0] keep,
    output logic [SW-1:0] left_word,
    output logic [SW-1:0] cur_word
);
    localparam int IW = $clog2(SW);

    logic [SW-1:0] word_q;
    logic [CW-1:0] pos;
    logic          ins;

    assign ins = shift_en && (bit_idx < keep);
    assign pos = CW'(SW - 1) - bit_idx;

    always_comb begin
        cur_word = word_q;
        if (ins) cur_word[pos[IW-1:0]] = sd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q    <= '0;
            left_word <= '0;
        end else if (end_left) begin
            left_word <= cur_word;
            word_q    <= '0;
        end else if (end_right) begin
            word_q    <= '0;
        end else begin
            word_q    <= cur_word;
        end
    end
endmodule

// File: rtl/tri_lane_pcm_rx.sv
module tri_lane_pcm_rx
    import pcm_rx_pkg::*;
#(
    parameter int LANES       = 3,
    parameter int SAMPLE_W    = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bit_clk,
    input  logic                      word_clk,
    input  logic [2:0]                lane_data,
    input  logic [1:0]                word_len,
    input  logic                      bit_clk_inv,
    output logic [3*SAMPLE_W-1:0]     left_samples,
    output logic [3*SAMPLE_W-1:0]     right_samples,
    output logic                      samples_valid
);
    localparam int CW    = 6;
    localparam int SYN_W = LANES + 2;

    logic [SYN_W-1:0] syn_out;
    logic             shift_en, end_left, end_right;
    logic [CW-1:0]    bit_idx, keep;
    logic [SAMPLE_W-1:0] lane_left [LANES];
    logic [SAMPLE_W-1:0] lane_cur  [LANES];

    pcm_rx_sync #(.W(SYN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({lane_data[LANES-1:0], word_clk, bit_clk}),
        .dout (syn_out)
    );

    pcm_rx_framer #(.CW(CW)) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (syn_out[0]),
        .ws_s     (syn_out[1]),
        .inv      (bit_clk_inv),
        .shift_en (shift_en),
        .end_left (end_left),
        .end_right(end_right),
        .bit_idx  (bit_idx)
    );

    assign keep = kept_bits(wlen_e'(word_len));

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        pcm_rx_lane #(.SW(SAMPLE_W), .CW(CW)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .sd       (syn_out[2+l]),
            .shift_en (shift_en),
            .end_left (end_left),
            .end_right(end_right),
            .bit_idx  (bit_idx),
            .keep     (keep),
            .left_word(lane_left[l]),
            .cur_word (lane_cur[l])
        );

        // R4: 16-bit words leave the low bits zero
        assert_pad16_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (samples_valid && word_len == 2'b00) |->
            (left_samples[l*SAMPLE_W +: (SAMPLE_W-16)] == '0 &&
             right_samples[l*SAMPLE_W +: (SAMPLE_W-16)] == '0));

        // R5: 20-bit words leave the low bits zero
        assert_pad20_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (samples_valid && word_len == 2'b01) |->
            (left_samples[l*SAMPLE_W +: (SAMPLE_W-20)] == '0 &&
             right_samples[l*SAMPLE_W +: (SAMPLE_W-20)] == '0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_samples  <= '0;
            right_samples <= '0;
            samples_valid <= 1'b0;
        end else begin
            samples_valid <= end_right;
            if (end_right) begin
                for (int l = 0; l < LANES; l++) begin
                    left_samples[l*SAMPLE_W +: SAMPLE_W]  <= lane_left[l];
                    right_samples[l*SAMPLE_W +: SAMPLE_W] <= lane_cur[l];
                end
            end
        end
    end

    // R10: strobe lasts one cycle
    assert_valid_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        samples_valid |=> !samples_valid);

    // R10: samples move only together with the strobe
    assert_hold_between_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(left_samples) || !$stable(right_samples)) |-> samples_valid);
endmodule

// File: tb/tri_lane_pcm_rx_tb.sv
module tri_lane_pcm_rx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_clk = 1'b0;
    logic        word_clk = 1'b0;
    logic [2:0]  lane_data = '0;
    logic [1:0]  word_len = 2'b00;
    logic        bit_clk_inv = 1'b0;
    logic [71:0] left_samples, right_samples;
    logic        samples_valid;

    int checks = 0;
    int failures = 0;
    int vcount = 0;
    bit done = 0;
    logic [71:0] cap_l = '0, cap_r = '0;
    logic carry [3] = '{1'b0, 1'b0, 1'b0};

    always #2 clk = ~clk;

    tri_lane_pcm_rx u_dut (
        .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .word_clk(word_clk),
        .lane_data(lane_data), .word_len(word_len), .bit_clk_inv(bit_clk_inv),
        .left_samples(left_samples), .right_samples(right_samples),
        .samples_valid(samples_valid)
    );

    always @(negedge clk) begin
        if (samples_valid) begin
            vcount = vcount + 1;
            cap_l  = left_samples;
            cap_r  = right_samples;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] expw(input logic [31:0] w, input int wb);
        if (wb >= 24) return 24'(w >> (wb - 24));
        return 24'(w << (24 - wb));
    endfunction

    function automatic logic bit_at(input logic [31:0] w, input int wb, input int k,
                                    input logic fill);
        if (k < wb) return w[wb-1-k];
        return fill;
    endfunction

    // one bit-clock period: drive edge, data one clock later, then sample edge
    task automatic bclk_cycle(input logic ws_v, input logic [2:0] bits);
        bit_clk = bit_clk_inv;
        @(negedge clk);
        word_clk  = ws_v;
        lane_data = bits;
        repeat (2) @(negedge clk);
        bit_clk = ~bit_clk_inv;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_phase(input logic ws_v, input logic [31:0] w [3], input int wb,
                              input int plen, input logic fill);
        for (int j = 0; j < plen; j++) begin
            logic [2:0] b;
            for (int l = 0; l < 3; l++)
                b[l] = (j == 0) ? carry[l] : bit_at(w[l], wb, j-1, fill);
            bclk_cycle(ws_v, b);
        end
        for (int l = 0; l < 3; l++) carry[l] = bit_at(w[l], wb, plen-1, fill);
    endtask

    // dummy zero right phase, one full frame, then the closing word-clock fall
    task automatic run_frame(input string req, input int wb, input int plen, input logic fill,
                             input logic [31:0] lw [3], input logic [31:0] rw [3]);
        logic [31:0] z [3] = '{32'h0, 32'h0, 32'h0};
        send_phase(1'b1, z, wb, plen, 1'b0);
        send_phase(1'b0, lw, wb, plen, fill);
        send_phase(1'b1, rw, wb, plen, fill);
        vcount = 0;
        send_phase(1'b0, z, wb, 1, 1'b0);
        repeat (8) @(negedge clk);
        chk({req, " R10 one strobe"}, 32'(vcount), 32'd1);
        for (int l = 0; l < 3; l++) begin
            chk({req, " R11 left lane"},  32'(cap_l[l*24 +: 24]), 32'(expw(lw[l], wb)));
            chk({req, " R11 right lane"}, 32'(cap_r[l*24 +: 24]), 32'(expw(rw[l], wb)));
        end
    endtask

    task automatic t_reset_hunt();
        logic [31:0] j [3] = '{32'hFFFF, 32'hA5A5, 32'h1234};
        chk("R1 valid", 32'(samples_valid), 32'd0);
        chk("R1 left",  32'(left_samples[31:0] | left_samples[71:32]), 32'd0);
        chk("R1 right", 32'(right_samples[31:0] | right_samples[71:32]), 32'd0);
        vcount = 0;
        send_phase(1'b0, j, 16, 16, 1'b0);
        send_phase(1'b1, j, 16, 16, 1'b0);
        send_phase(1'b0, j, 16, 1, 1'b0);
        repeat (8) @(negedge clk);
        chk("R12 no frame before first fall", 32'(vcount), 32'd0);
    endtask

    task automatic t_wl16();
        logic [31:0] lw [3] = '{32'h8001, 32'h7FFE, 32'h1357};
        logic [31:0] rw [3] = '{32'hC3A5, 32'h0F0F, 32'hFFFF};
        word_len = 2'b00;
        run_frame("R4 R2 R8 16-bit", 16, 16, 1'b0, lw, rw);
    endtask

    task automatic t_wl20_tail();
        logic [31:0] lw [3] = '{32'hABCDE, 32'h80001, 32'h12345};
        logic [31:0] rw [3] = '{32'h7FFFF, 32'h5A5A5, 32'h00001};
        word_len = 2'b01;
        run_frame("R5 R9 20-bit ones tail", 20, 32, 1'b1, lw, rw);
    endtask

    task automatic t_wl24();
        logic [31:0] lw [3] = '{32'h800001, 32'h7FFFFE, 32'h123456};
        logic [31:0] rw [3] = '{32'hFEDCBA, 32'h000001, 32'hA5A5A5};
        word_len = 2'b10;
        run_frame("R6 24-bit", 24, 24, 1'b0, lw, rw);
    endtask

    task automatic t_wl24_short();
        logic [31:0] lw [3] = '{32'h9ABC, 32'h0001, 32'hFFFF};
        logic [31:0] rw [3] = '{32'h8000, 32'h4321, 32'h00F0};
        word_len = 2'b10;
        run_frame("R13 short word in 24-bit mode", 16, 32, 1'b0, lw, rw);
    endtask

    task automatic t_wl32();
        logic [31:0] lw [3] = '{32'h89ABCDEF, 32'h7FFFFFFF, 32'h00000155};
        logic [31:0] rw [3] = '{32'h80000000, 32'h123456FF, 32'hFEDCBA98};
        word_len = 2'b11;
        run_frame("R7 32-bit", 32, 32, 1'b0, lw, rw);
    endtask

    task automatic t_inverted();
        logic [31:0] lw [3] = '{32'h5A5A5A, 32'hC00003, 32'h0F1E2D};
        logic [31:0] rw [3] = '{32'h3C3C3C, 32'h800000, 32'hFFFFFF};
        word_len = 2'b10;
        bit_clk_inv = 1'b1;
        run_frame("R3 falling-edge sampling", 24, 24, 1'b0, lw, rw);
        bit_clk_inv = 1'b0;
    endtask

    task automatic t_back_normal();
        logic [31:0] lw [3] = '{32'hF001, 32'h8888, 32'h0246};
        logic [31:0] rw [3] = '{32'h1111, 32'hEDCB, 32'h7000};
        word_len = 2'b00;
        run_frame("R2 rising-edge sampling again", 16, 20, 1'b0, lw, rw);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset_hunt();
        t_wl16();
        t_wl20_tail();
        t_wl24();
        t_wl24_short();
        t_wl32();
        t_inverted();
        t_back_normal();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule